// File: doc/BRIEF.md
# DRAM strobe cycle decoder

This block sits on the device side of an asynchronous-style DRAM strobe interface. It watches the row strobe, column strobe, write enable and output enable, all active low and sampled by a fast clock. From the order in which the strobe edges arrive, it works out what kind of memory cycle the controller is running. It also latches the row and column addresses, keeps the device's internal refresh row counter, and tracks whether the data pins would be driven. That tracking includes the extended-data-out behaviour, in which read data stays on the pins after the column strobe rises.

A typical use is as a protocol checker placed next to a DRAM controller. It can also act as the front end of a behavioural memory model. The strobes must be synchronous to `clk`, and every pulse must last at least one clock. Edges that fall in the same sample count as simultaneous. At each rising edge of the row strobe, the block emits a one-cycle summary of the cycle that has just finished. An illegal edge order raises an error flag, which stays set until the row strobe is high again.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After synchronous reset, cyc_type is 0, err_flag, dq_oe and done_pulse are 0, and ref_row is 0.
- R2: A falling row strobe with the column strobe high latches addr into row_addr and shows cyc_type 4. A later falling column strobe latches addr into col_addr. That column access is a read (code 1) if we_n is high at that sample, and an early write (code 2) if we_n is low.
- R3: In a read, a falling we_n while the row strobe is still low changes cyc_type to 3 (read-modify-write).
- R4: A row strobe pulse with no column strobe fall is a row-only refresh. It ends with done_type 4, done_row equal to the row address, and dq_oe held at 0.
- R5: If the column strobe was already low in the sample before the row strobe falls, the cycle is a column-first refresh (code 5). row_addr takes ref_row, and ref_row then advances by one, modulo 2^AW.
- R6: If the column strobe stays low after an access while the row strobe rises and falls again, the new cycle is a hidden refresh (code 6). It uses and advances ref_row, and dq_oe keeps its read-data state.
- R7: In a column-first refresh, cyc_type becomes 7 (self refresh) once the row strobe has been sampled low SELF_CYC times. After SELF_CYC-1 samples it is still 5.
- R8: dq_oe rises one clock after a read column strobe with oe_n low and stays set while the column strobe is high and the row strobe is low. It clears one clock after oe_n is high, after we_n is low, or after both strobes are high.
- R9: Each of these sets err_flag with cyc_type 0:
  - both strobes fall in the same sample;
  - the column strobe falls again during a refresh;
  - the row strobe falls in the same sample as the column strobe rises while held.

  err_flag clears when the row strobe is sampled high, and no done_pulse is given.
- R10: Every legal cycle ends with a one-clock done_pulse at the row strobe rise. The pulse carries done_type and done_row for that cycle.
- R11: Within one row strobe low period, each further column strobe fall latches a new col_addr and reclassifies the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| cyc_type | output | 3 | Live classification of the current cycle |
| err_flag | output | 1 | Illegal edge order seen in this row period |
| dq_oe | output | 1 | Data pins would be driven |
| row_addr | output | AW | Row latched for the current cycle |
| col_addr | output | AW | Last latched column |
| ref_row | output | AW | Next internal refresh row |
| done_pulse | output | 1 | One clock at the end of a legal cycle |
| done_type | output | 3 | Type of the cycle just ended |
| done_row | output | AW | Row of the cycle just ended |

## Verification
Each cycle kind is driven as its own edge sequence. Reads and early writes differ only in the level of we_n at the column fall. A read-modify-write differs from a read only by a later we_n fall. The two internal-counter refreshes are told apart by whether the column strobe was low from idle or was held over from an access. The self-refresh threshold is probed one sample either side of its limit. Page-mode column changes, output-enable toggling, all three illegal orders and a full wrap of the refresh counter show that the latches, the output-hold state and the error recovery each behave on their own.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        T_NONE  = 3'd0,
        T_READ  = 3'd1,
        T_EWR   = 3'd2,
        T_RMW   = 3'd3,
        T_RONLY = 3'd4,
        T_CBR   = 3'd5,
        T_HID   = 3'd6,
        T_SELF  = 3'd7
    } cyc_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ROW, S_COL, S_REF, S_HOLD, S_HID, S_ERR
    } phase_t;

    // strobe levels, active low, ras in the top bit
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    typedef struct packed {
        strobe_t lvl;
        strobe_t prev;
        strobe_t fall;
        strobe_t rise;
    } edges_t;

    function automatic cyc_t access_kind(input logic we_lvl);
        return we_lvl ? T_READ : T_EWR;
    endfunction

endpackage

// File: rtl/dcd_edges.sv
module dcd_edges
    import dcd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   strobes,
    output edges_t       ev
);
    logic [3:0] prev_q;

    genvar i;
    generate
        for (i = 0; i < 4; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) prev_q[i] <= 1'b1;
                else     prev_q[i] <= strobes[i];
            end
        end
    endgenerate

    assign ev.lvl  = strobes;
    assign ev.prev = prev_q;
    assign ev.fall = prev_q & ~strobes;
    assign ev.rise = ~prev_q & strobes;

endmodule

// File: rtl/dcd_refcnt.sv
module dcd_refcnt #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dcd_outen.sv
module dcd_outen
    import dcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  edges_t ev,
    input  logic   col_hit,
    output logic   dq_oe
);
    logic dv_q, dv_d, oe_d, both_high;

    assign both_high = ev.lvl.ras & ev.lvl.cas;

    always_comb begin
        if (both_high)        dv_d = 1'b0;
        else if (col_hit)     dv_d = ev.lvl.we;
        else if (ev.fall.we)  dv_d = 1'b0;
        else                  dv_d = dv_q;
        oe_d = dv_d & ~ev.lvl.oe & ev.lvl.we & ~both_high;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dv_q  <= 1'b0;
            dq_oe <= 1'b0;
        end else begin
            dv_q  <= dv_d;
            dq_oe <= oe_d;
        end
    end

    assert_we_off_R8: assert property (@(posedge clk) disable iff (rst)
        !ev.lvl.we |=> !dq_oe);
    assert_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
        ev.lvl.oe |=> !dq_oe);
    assert_idle_off_R8: assert property (@(posedge clk) disable iff (rst)
        (ev.lvl.ras && ev.lvl.cas) |=> !dq_oe);

endmodule

// File: rtl/dcd_fsm.sv
module dcd_fsm
    import dcd_pkg::*;
#(
    parameter int AW       = 11,
    parameter int SELF_CYC = 25000
) (
    input  logic          clk,
    input  logic          rst,
    input  edges_t        ev,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_row,
    output logic          ref_inc,
    output logic          col_hit,
    output cyc_t          cyc_type,
    output logic          err_flag,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q,
    output logic          done_pulse,
    output cyc_t          done_type,
    output logic [AW-1:0] done_row
);
    localparam int SW = $clog2(SELF_CYC + 1);

    phase_t        st_q, st_d;
    cyc_t          typ_d, dnt_d;
    logic [AW-1:0] row_d, col_d, dnr_d;
    logic [SW-1:0] scnt_q, scnt_d;
    logic          dn_d;

    always_comb begin
        st_d = st_q; typ_d = cyc_type; row_d = row_q; col_d = col_q;
        scnt_d = scnt_q; ref_inc = 1'b0; col_hit = 1'b0;
        dn_d = 1'b0; dnt_d = done_type; dnr_d = done_row;
        unique case (st_q)
            S_IDLE: if (ev.fall.ras) begin
                if (ev.fall.cas) begin
                    st_d = S_ERR; typ_d = T_NONE;
                end else if (!ev.prev.cas) begin
                    st_d = S_REF; typ_d = T_CBR; row_d = ref_row;
                    ref_inc = 1'b1; scnt_d = SW'(1);
                end else begin
                    st_d = S_ROW; typ_d = T_RONLY; row_d = addr;
                end
            end
            S_ROW: if (ev.rise.ras) begin
                st_d = S_IDLE; typ_d = T_NONE;
                dn_d = 1'b1; dnt_d = cyc_type; dnr_d = row_q;
            end else if (ev.fall.cas) begin
                st_d = S_COL; col_d = addr; col_hit = 1'b1;
                typ_d = access_kind(ev.lvl.we);
            end
            S_COL: if (ev.rise.ras) begin
                st_d = ev.lvl.cas ? S_IDLE : S_HOLD; typ_d = T_NONE;
                dn_d = 1'b1; dnt_d = cyc_type; dnr_d = row_q;
            end else if (ev.rise.cas) begin
                st_d = S_ROW;
            end else if (ev.fall.we && cyc_type == T_READ) begin
                typ_d = T_RMW;
            end
            S_REF: if (ev.rise.ras) begin
                st_d = S_IDLE; typ_d = T_NONE;
                dn_d = 1'b1; dnt_d = cyc_type; dnr_d = row_q;
            end else if (ev.fall.cas) begin
                st_d = S_ERR; typ_d = T_NONE;
            end else if (scnt_q != SW'(SELF_CYC)) begin
                scnt_d = scnt_q + SW'(1);
                if (scnt_q + SW'(1) == SW'(SELF_CYC)) typ_d = T_SELF;
            end
            S_HOLD: if (ev.fall.ras && ev.rise.cas) begin
                st_d = S_ERR; typ_d = T_NONE;
            end else if (ev.fall.ras) begin
                st_d = S_HID; typ_d = T_HID; row_d = ref_row; ref_inc = 1'b1;
            end else if (ev.rise.cas) begin
                st_d = S_IDLE;
            end
            S_HID: if (ev.rise.ras) begin
                st_d = ev.lvl.cas ? S_IDLE : S_HOLD; typ_d = T_NONE;
                dn_d = 1'b1; dnt_d = cyc_type; dnr_d = row_q;
            end else if (ev.fall.cas) begin
                st_d = S_ERR; typ_d = T_NONE;
            end
            S_ERR: if (ev.lvl.ras) begin
                st_d = S_IDLE; typ_d = T_NONE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE; cyc_type <= T_NONE; row_q <= '0; col_q <= '0;
            scnt_q <= '0; done_pulse <= 1'b0; done_type <= T_NONE; done_row <= '0;
        end else begin
            st_q <= st_d; cyc_type <= typ_d; row_q <= row_d; col_q <= col_d;
            scnt_q <= scnt_d; done_pulse <= dn_d; done_type <= dnt_d; done_row <= dnr_d;
        end
    end

    assign err_flag = (st_q == S_ERR);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);
    assert_done_typed_R10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> done_type != T_NONE);
    assert_err_untyped_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> cyc_type == T_NONE);
    assert_refresh_ras_low_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == T_CBR) |-> !$past(ev.lvl.ras));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int AW       = 11,
    parameter int SELF_CYC = 25000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic [2:0]    cyc_type,
    output logic          err_flag,
    output logic          dq_oe,
    output logic [AW-1:0] row_addr,
    output logic [AW-1:0] col_addr,
    output logic [AW-1:0] ref_row,
    output logic          done_pulse,
    output logic [2:0]    done_type,
    output logic [AW-1:0] done_row
);
    edges_t ev;
    logic   ref_inc, col_hit;
    cyc_t   typ_w, dnt_w;

    dcd_edges u_edges (
        .clk(clk), .rst(rst), .strobes({ras_n, cas_n, we_n, oe_n}), .ev(ev)
    );

    dcd_refcnt #(.AW(AW)) u_refcnt (
        .clk(clk), .rst(rst), .inc(ref_inc), .cnt(ref_row)
    );

    dcd_fsm #(.AW(AW), .SELF_CYC(SELF_CYC)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .addr(addr), .ref_row(ref_row),
        .ref_inc(ref_inc), .col_hit(col_hit), .cyc_type(typ_w),
        .err_flag(err_flag), .row_q(row_addr), .col_q(col_addr),
        .done_pulse(done_pulse), .done_type(dnt_w), .done_row(done_row)
    );

    dcd_outen u_outen (
        .clk(clk), .rst(rst), .ev(ev), .col_hit(col_hit), .dq_oe(dq_oe)
    );

    assign cyc_type  = typ_w;
    assign done_type = dnt_w;

endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    localparam int AW = 11;
    localparam int SC = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [2:0] cyc_type, done_type;
    logic err_flag, dq_oe, done_pulse;
    logic [AW-1:0] row_addr, col_addr, ref_row, done_row;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.AW(AW), .SELF_CYC(SC)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type), .err_flag(err_flag),
        .dq_oe(dq_oe), .row_addr(row_addr), .col_addr(col_addr),
        .ref_row(ref_row), .done_pulse(done_pulse), .done_type(done_type),
        .done_row(done_row)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_done(input string tag, input int t, input logic [AW-1:0] r);
        chk({tag, " done_pulse"}, 32'(done_pulse), 1);
        chk({tag, " done_type"}, 32'(done_type), 32'(t));
        chk({tag, " done_row"}, 32'(done_row), 32'(r));
    endtask

    task automatic t_reset();
        chk("R1 type", 32'(cyc_type), 0);
        chk("R1 err", 32'(err_flag), 0);
        chk("R1 dq", 32'(dq_oe), 0);
        chk("R1 done", 32'(done_pulse), 0);
        chk("R1 refrow", 32'(ref_row), 0);
    endtask

    task automatic t_read_page();
        addr = 11'h155; ras_n = 0; step();
        chk("R2 row-only before column", 32'(cyc_type), 4);
        chk("R2 row latch", 32'(row_addr), 32'h155);
        addr = 11'h2AA; oe_n = 0; cas_n = 0; step();
        chk("R2 read type", 32'(cyc_type), 1);
        chk("R2 col latch", 32'(col_addr), 32'h2AA);
        chk("R8 dq on", 32'(dq_oe), 1);
        cas_n = 1; step();
        chk("R8 data held with column high", 32'(dq_oe), 1);
        oe_n = 1; step();
        chk("R8 oe high off", 32'(dq_oe), 0);
        oe_n = 0; step();
        chk("R8 oe low back on", 32'(dq_oe), 1);
        addr = 11'h0F0; we_n = 0; cas_n = 0; step();
        chk("R11 page col", 32'(col_addr), 32'h0F0);
        chk("R11 reclassified write", 32'(cyc_type), 2);
        chk("R8 write off", 32'(dq_oe), 0);
        we_n = 1; ras_n = 1; cas_n = 1; oe_n = 1; step();
        chk_done("R10 page", 2, 11'h155);
        step();
        chk("R10 single pulse", 32'(done_pulse), 0);
    endtask

    task automatic t_ewrite();
        addr = 11'h00A; ras_n = 0; step();
        addr = 11'h00B; we_n = 0; cas_n = 0; step();
        chk("R2 early write", 32'(cyc_type), 2);
        chk("R2 early write dq", 32'(dq_oe), 0);
        ras_n = 1; cas_n = 1; we_n = 1; step();
        chk_done("R2 ewrite", 2, 11'h00A);
    endtask

    task automatic t_rmw();
        addr = 11'h321; ras_n = 0; step();
        oe_n = 0; cas_n = 0; step();
        chk("R3 read first", 32'(cyc_type), 1);
        we_n = 0; step();
        chk("R3 rmw", 32'(cyc_type), 3);
        chk("R8 we low off", 32'(dq_oe), 0);
        ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; step();
        chk_done("R3 rmw", 3, 11'h321);
    endtask

    task automatic t_rasonly();
        addr = 11'h7FE; oe_n = 0; ras_n = 0; step();
        addr = 11'h001; step();
        chk("R4 dq off", 32'(dq_oe), 0);
        ras_n = 1; oe_n = 1; step();
        chk_done("R4 row-only", 4, 11'h7FE);
    endtask

    task automatic t_cbr();
        logic [AW-1:0] k;
        k = ref_row;
        cas_n = 0; step();
        ras_n = 0; step();
        chk("R5 type", 32'(cyc_type), 5);
        chk("R5 row from counter", 32'(row_addr), 32'(k));
        chk("R5 counter step", 32'(ref_row), 32'(k + 1'b1));
        chk("R5 dq off", 32'(dq_oe), 0);
        ras_n = 1; step();
        chk_done("R5 cbr", 5, k);
        cas_n = 1; step();
    endtask

    task automatic t_hidden();
        logic [AW-1:0] k;
        addr = 11'h033; ras_n = 0; step();
        addr = 11'h044; oe_n = 0; cas_n = 0; step();
        ras_n = 1; step();
        chk_done("R6 preceding read", 1, 11'h033);
        chk("R6 dq held", 32'(dq_oe), 1);
        k = ref_row;
        ras_n = 0; step();
        chk("R6 type", 32'(cyc_type), 6);
        chk("R6 row", 32'(row_addr), 32'(k));
        chk("R6 counter", 32'(ref_row), 32'(k + 1'b1));
        chk("R6 dq stays on", 32'(dq_oe), 1);
        ras_n = 1; step();
        chk_done("R6 hidden", 6, k);
        cas_n = 1; step();
        chk("R8 both high off", 32'(dq_oe), 0);
        oe_n = 1;
    endtask

    task automatic t_self();
        cas_n = 0; step();
        ras_n = 0;
        for (int i = 0; i < SC - 1; i++) step();
        chk("R7 below limit", 32'(cyc_type), 5);
        step();
        chk("R7 self", 32'(cyc_type), 7);
        ras_n = 1; step();
        chk("R7 done self", 32'(done_type), 7);
        cas_n = 1; step();
    endtask

    task automatic t_errors();
        ras_n = 0; cas_n = 0; step();
        chk("R9 same-sample fall", 32'(err_flag), 1);
        chk("R9 type cleared", 32'(cyc_type), 0);
        ras_n = 1; cas_n = 1; step();
        chk("R9 clear", 32'(err_flag), 0);
        chk("R9 no done", 32'(done_pulse), 0);
        cas_n = 0; step(); ras_n = 0; step();
        cas_n = 1; step(); cas_n = 0; step();
        chk("R9 column during refresh", 32'(err_flag), 1);
        ras_n = 1; step();
        chk("R9 clear 2", 32'(err_flag), 0);
        chk("R9 no done 2", 32'(done_pulse), 0);
        cas_n = 1; step();
        ras_n = 0; step(); cas_n = 0; step(); ras_n = 1; step();
        ras_n = 0; cas_n = 1; step();
        chk("R9 hold conflict", 32'(err_flag), 1);
        ras_n = 1; step();
        chk("R9 clear 3", 32'(err_flag), 0);
    endtask

    task automatic t_wrap();
        logic [AW-1:0] s0;
        s0 = ref_row;
        for (int i = 0; i < (1 << AW); i++) begin
            cas_n = 0; step(); ras_n = 0; step(); ras_n = 1; step(); cas_n = 1; step();
        end
        chk("R5 counter wraps", 32'(ref_row), 32'(s0));
    endtask

    initial begin
        repeat (3) step();
        rst = 0; step();
        t_reset();
        t_read_page();
        t_ewrite();
        t_rmw();
        t_rasonly();
        t_cbr();
        t_hidden();
        t_self();
        t_errors();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule